// File: doc/BRIEF.md
# Grouped Edge Interrupt Status Unit

This block watches thirteen already-synchronized pin levels and records the selected edges on each pin in sticky status bits. Each pin has its own two-bit detect mode, which picks falling edges, rising edges, both, or nothing. The pins form two groups of unequal size. The lower group holds pins 0 to 6, and the upper group holds pins 7 to 12. Each group has one status byte and one mask byte on a small register port.

Software reads the status bytes to find out which pins have fired. It clears bits by writing ones to them, and it uses the mask bytes to choose which pending bits may reach the single level-sensitive interrupt line. A pin whose mask bit is set still records edges. Unmasking that pin later raises the interrupt if its bit is still pending.

The register port has no data stream and therefore no valid/ready handshake. A write takes effect on the clock edge where `bus_wr_en` is high and never stalls. `bus_rdata` follows `bus_addr` combinationally, so the port applies no back-pressure.

Top module: `grp_edge_irq`

## Requirements
- R1: After reset every status bit reads 0, the mask bytes read 0x7F (lower group) and 0x3F (upper group), and `irq` is 0.
- R2: A pin in detect mode 2 sets its status bit on a 0-to-1 change of its level and not on a 1-to-0 change.
- R3: A pin in detect mode 1 sets its status bit on a 1-to-0 change of its level and not on a 0-to-1 change.
- R4: Detect mode 3 sets the status bit on either change, and detect mode 0 never sets it. The mode of pin n is `pin_mode[2n+1:2n]`.
- R5: Pin n below 7 is bit n of the lower status byte at address 0x4E0B and of the lower mask byte at 0x4E19. Pin n from 7 to 12 is bit n-7 of the upper status byte at 0x4E0C and of the upper mask byte at 0x4E1A.
- R6: Writing a status byte clears each bit where the written data has a 1 and leaves each bit where it has a 0. A set status bit stays set until it is cleared this way.
- R7: If a detected edge and a clearing write reach the same status bit on the same clock edge, the bit ends up set.
- R8: `irq` is 1 exactly when some status bit is 1 and its mask bit is 0. Status bits keep latching while masked.
- R9: Bit 7 of the lower bytes and bits 7:6 of the upper bytes read 0 and ignore writes. Any address other than the four register addresses reads 0, and writes to such addresses change nothing.
- R10: An edge is a difference between the level at a clock edge and the level at the previous clock edge, so a one-cycle pulse counts. The first clock edge after reset detects no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl | input | 13 | Synchronized pin levels, bit n is pin n |
| pin_mode | input | 26 | Detect mode per pin, two bits each (0 off, 1 fall, 2 rise, 3 both) |
| bus_addr | input | 16 | Register address |
| bus_wr_en | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The properties assume that `pin_lvl` is already synchronous to `clk` and that `bus_addr` is stable for the whole cycle in which `bus_wdata` and `bus_wr_en` apply. They also assume that `pin_mode` changes only between edges of interest. The stimulus changes pins, modes and bus signals only at falling clock edges. It changes a pin's mode only while that pin's level is held constant, so no unintended edge is recorded during a mode switch. Every status check is preceded by an explicit clearing write, so each expected byte depends only on the edge under test.

// File: rtl/gei_pkg.sv
package gei_pkg;

  typedef enum logic [1:0] {
    DET_OFF  = 2'd0,
    DET_FALL = 2'd1,
    DET_RISE = 2'd2,
    DET_BOTH = 2'd3
  } det_mode_e;

  // Decide whether a pin's observed transition is one its mode records.
  function automatic logic edge_match(det_mode_e mode, logic rise, logic fall);
    logic hit;
    case (mode)
      DET_FALL: hit = fall;
      DET_RISE: hit = rise;
      DET_BOTH: hit = rise | fall;
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/gei_edge_det.sv
module gei_edge_det
  import gei_pkg::*;
#(
  parameter int NUM_PINS = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_lvl,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  output logic [NUM_PINS-1:0]   hit
);

  logic [NUM_PINS-1:0] prev_q;
  logic                primed_q;

  // Previous-cycle levels; primed_q blocks a false edge right after reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= pin_lvl;
      primed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    det_mode_e mode;
    logic      rise;
    logic      fall;
    assign mode   = det_mode_e'(pin_mode[2*i +: 2]);
    assign rise   = primed_q &  pin_lvl[i] & ~prev_q[i];
    assign fall   = primed_q & ~pin_lvl[i] &  prev_q[i];
    assign hit[i] = edge_match(mode, rise, fall);
  end

endmodule

// File: rtl/gei_status_grp.sv
module gei_status_grp #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hit,
  input  logic             stat_wr,
  input  logic             mask_wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] stat_q,
  output logic [WIDTH-1:0] mask_q,
  output logic             pend
);

  logic [WIDTH-1:0] clr;

  assign clr = stat_wr ? wdata : '0;

  // Sticky status: a new edge is ORed in after the clear, so it wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_wr) begin
      mask_q <= wdata;
    end
  end

  assign pend = |(stat_q & ~mask_q);

endmodule

// File: rtl/gei_regbus.sv
module gei_regbus #(
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter int                G0_W       = 7,
  parameter int                G1_W       = 6,
  parameter logic [ADDR_W-1:0] STAT0_ADDR = 16'h4E0B,
  parameter logic [ADDR_W-1:0] MASK0_ADDR = 16'h4E19
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [G0_W-1:0]   stat0,
  input  logic [G0_W-1:0]   mask0,
  input  logic [G1_W-1:0]   stat1,
  input  logic [G1_W-1:0]   mask1,
  output logic [1:0]        stat_wr,
  output logic [1:0]        mask_wr,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] STAT1_ADDR = STAT0_ADDR + 1'b1;
  localparam logic [ADDR_W-1:0] MASK1_ADDR = MASK0_ADDR + 1'b1;

  logic [1:0] stat_sel;
  logic [1:0] mask_sel;

  assign stat_sel = {bus_addr == STAT1_ADDR, bus_addr == STAT0_ADDR};
  assign mask_sel = {bus_addr == MASK1_ADDR, bus_addr == MASK0_ADDR};

  assign stat_wr = bus_wr_en ? stat_sel : 2'b00;
  assign mask_wr = bus_wr_en ? mask_sel : 2'b00;

  // Unused upper bits and unmapped addresses return zero.
  always_comb begin
    rdata = '0;
    if (stat_sel[0]) rdata = DATA_W'(stat0);
    if (stat_sel[1]) rdata = DATA_W'(stat1);
    if (mask_sel[0]) rdata = DATA_W'(mask0);
    if (mask_sel[1]) rdata = DATA_W'(mask1);
  end

endmodule

// File: rtl/grp_edge_irq.sv
module grp_edge_irq #(
  parameter int                NUM_PINS   = 13,
  parameter int                G0_PINS    = 7,
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STAT0_ADDR = 16'h4E0B,
  parameter logic [ADDR_W-1:0] MASK0_ADDR = 16'h4E19
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_lvl,
  input  logic [2*NUM_PINS-1:0] pin_mode,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr_en,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  irq
);

  localparam int G1_PINS = NUM_PINS - G0_PINS;

  logic [NUM_PINS-1:0] edge_hit;
  logic [G0_PINS-1:0]  stat_g0;
  logic [G0_PINS-1:0]  mask_g0;
  logic [G1_PINS-1:0]  stat_g1;
  logic [G1_PINS-1:0]  mask_g1;
  logic [1:0]          stat_wr;
  logic [1:0]          mask_wr;
  logic [1:0]          pend_g;
  logic                wdata_unused;

  assign wdata_unused = ^bus_wdata;

  gei_edge_det #(.NUM_PINS(NUM_PINS)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_lvl  (pin_lvl),
    .pin_mode (pin_mode),
    .hit      (edge_hit)
  );

  gei_status_grp #(.WIDTH(G0_PINS)) u_grp0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (edge_hit[G0_PINS-1:0]),
    .stat_wr (stat_wr[0]),
    .mask_wr (mask_wr[0]),
    .wdata   (bus_wdata[G0_PINS-1:0]),
    .stat_q  (stat_g0),
    .mask_q  (mask_g0),
    .pend    (pend_g[0])
  );

  gei_status_grp #(.WIDTH(G1_PINS)) u_grp1 (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (edge_hit[NUM_PINS-1:G0_PINS]),
    .stat_wr (stat_wr[1]),
    .mask_wr (mask_wr[1]),
    .wdata   (bus_wdata[G1_PINS-1:0]),
    .stat_q  (stat_g1),
    .mask_q  (mask_g1),
    .pend    (pend_g[1])
  );

  gei_regbus #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .G0_W       (G0_PINS),
    .G1_W       (G1_PINS),
    .STAT0_ADDR (STAT0_ADDR),
    .MASK0_ADDR (MASK0_ADDR)
  ) u_bus (
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .stat0     (stat_g0),
    .mask0     (mask_g0),
    .stat1     (stat_g1),
    .mask1     (mask_g1),
    .stat_wr   (stat_wr),
    .mask_wr   (mask_wr),
    .rdata     (bus_rdata)
  );

  assign irq = |pend_g;

endmodule

// File: rtl/gei_chk.sv
module gei_chk #(
  parameter int                NUM_PINS   = 13,
  parameter int                G0_PINS    = 7,
  parameter int                ADDR_W     = 16,
  parameter int                DATA_W     = 8,
  parameter logic [ADDR_W-1:0] STAT0_ADDR = 16'h4E0B,
  parameter logic [ADDR_W-1:0] MASK0_ADDR = 16'h4E19
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [2*NUM_PINS-1:0]         pin_mode,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_wr_en,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic                          irq,
  input logic [NUM_PINS-1:0]           hit,
  input logic [G0_PINS-1:0]            stat0,
  input logic [G0_PINS-1:0]            mask0,
  input logic [NUM_PINS-G0_PINS-1:0]   stat1,
  input logic [NUM_PINS-G0_PINS-1:0]   mask1
);

  localparam logic [DATA_W-1:0] G0_VALID = DATA_W'((64'd1 << G0_PINS) - 1);

  logic [NUM_PINS-1:0] mode_off;
  logic                chk_unused;

  assign chk_unused = ^{bus_wdata, stat1};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_off
    assign mode_off[i] = (pin_mode[2*i +: 2] == 2'b00);
  end

  // R4: a pin in mode 0 never reports an edge
  assert_mode_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & mode_off) == '0);

  // R6: ones written to the lower status byte clear unless an edge arrives
  assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == STAT0_ADDR) |=>
      ((stat0 & $past(bus_wdata[G0_PINS-1:0]) & ~$past(hit[G0_PINS-1:0])) == '0));

  // R6: without a status write or an edge the lower status byte holds
  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr_en && bus_addr == STAT0_ADDR) && hit[G0_PINS-1:0] == '0) |=> $stable(stat0));

  // R7: every detected edge lands in status, whatever the bus does
  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit[G0_PINS-1:0] != '0) |=> ((stat0 & $past(hit[G0_PINS-1:0])) == $past(hit[G0_PINS-1:0])));

  // R8: with every pin masked the request line stays low
  assert_all_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask0 && &mask1) |-> !irq);

  // R9: bits above the lower group read zero
  assert_unused_bits_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == STAT0_ADDR || bus_addr == MASK0_ADDR) |-> ((bus_rdata & ~G0_VALID) == '0));

endmodule

bind grp_edge_irq gei_chk #(
  .NUM_PINS   (NUM_PINS),
  .G0_PINS    (G0_PINS),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STAT0_ADDR (STAT0_ADDR),
  .MASK0_ADDR (MASK0_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pin_mode  (pin_mode),
  .bus_addr  (bus_addr),
  .bus_wr_en (bus_wr_en),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .hit       (edge_hit),
  .stat0     (stat_g0),
  .mask0     (mask_g0),
  .stat1     (stat_g1),
  .mask1     (mask_g1)
);

// File: tb/grp_edge_irq_tb.sv
module grp_edge_irq_tb;

  localparam int NP = 13;
  localparam int G0 = 7;
  localparam logic [15:0] A_ST0 = 16'h4E0B;
  localparam logic [15:0] A_ST1 = 16'h4E0C;
  localparam logic [15:0] A_MK0 = 16'h4E19;
  localparam logic [15:0] A_MK1 = 16'h4E1A;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   pin = '0;
  logic [2*NP-1:0] mode = '0;
  logic [15:0]     addr = '0;
  logic            we = 1'b0;
  logic [7:0]      wd = '0;
  logic [7:0]      rd;
  logic            irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  grp_edge_irq u_dut (
    .clk (clk), .rst_n (rst_n), .pin_lvl (pin), .pin_mode (mode),
    .bus_addr (addr), .bus_wr_en (we), .bus_wdata (wd),
    .bus_rdata (rd), .irq (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wd = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1 check(tag, rd, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R10: pin held high through reset in mode 3 must not register
    pin[3] = 1'b1;
    mode[7:6] = 2'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    rd_chk("R1 mask0 reset", A_MK0, 8'h7F);
    rd_chk("R1 mask1 reset", A_MK1, 8'h3F);
    rd_chk("R1 R10 status0 reset", A_ST0, 8'h00);
    rd_chk("R1 status1 reset", A_ST1, 8'h00);
    check("R1 irq reset", irq, 1'b0);
    @(negedge clk);
    mode = '0;
    @(negedge clk);
    pin[3] = 1'b0;

    wr(A_MK0, 8'h00);
    wr(A_MK1, 8'h00);

    // R2 R3 R4 R5 sweep: every pin, every mode, both directions
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [15:0] sa;
        int          bitn;
        logic        er;
        logic        ef;
        sa   = (p < G0) ? A_ST0 : A_ST1;
        bitn = (p < G0) ? p : p - G0;
        er   = (m == 2) || (m == 3);
        ef   = (m == 1) || (m == 3);
        @(negedge clk);
        mode = '0;
        mode[2*p +: 2] = 2'(m);
        wr(A_ST0, 8'hFF);
        wr(A_ST1, 8'hFF);
        @(negedge clk);
        pin[p] = 1'b1;
        rd_chk($sformatf("R2 R4 R5 rise pin%0d mode%0d", p, m), sa, 8'(er) << bitn);
        check($sformatf("R8 irq rise pin%0d mode%0d", p, m), irq, er);
        wr(A_ST0, 8'hFF);
        wr(A_ST1, 8'hFF);
        @(negedge clk);
        pin[p] = 1'b0;
        rd_chk($sformatf("R3 R4 R5 fall pin%0d mode%0d", p, m), sa, 8'(ef) << bitn);
        check($sformatf("R8 irq fall pin%0d mode%0d", p, m), irq, ef);
      end
    end

    // R6: write-one-to-clear on both bytes
    @(negedge clk);
    mode = {NP{2'b10}};
    wr(A_ST0, 8'hFF);
    wr(A_ST1, 8'hFF);
    @(negedge clk);
    pin = 13'b1_0001_0010_0101;
    @(negedge clk);
    pin = '0;
    rd_chk("R6 status0 set", A_ST0, 8'h25);
    rd_chk("R6 status1 set", A_ST1, 8'h22);
    wr(A_ST0, 8'h05);
    rd_chk("R6 status0 partial clear", A_ST0, 8'h20);
    wr(A_ST0, 8'h00);
    rd_chk("R6 status0 zero write", A_ST0, 8'h20);
    wr(A_ST1, 8'h02);
    rd_chk("R6 status1 partial clear", A_ST1, 8'h20);

    // R7: edge on pin 1 in the same cycle as a clear of bits 1 and 5
    @(negedge clk);
    pin[1] = 1'b1;
    addr = A_ST0; wd = 8'h22; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    pin[1] = 1'b0;
    rd_chk("R7 edge beats clear", A_ST0, 8'h02);

    // R8: masked latch, then unmask
    wr(A_ST0, 8'hFF);
    wr(A_ST1, 8'hFF);
    wr(A_MK0, 8'h7F);
    wr(A_MK1, 8'h3F);
    @(negedge clk);
    pin[9] = 1'b1;
    rd_chk("R8 latch while masked", A_ST1, 8'h04);
    check("R8 irq masked", irq, 1'b0);
    wr(A_MK1, 8'h3B);
    #1 check("R8 irq after unmask", irq, 1'b1);
    wr(A_MK1, 8'h3F);
    #1 check("R8 irq remasked", irq, 1'b0);
    wr(A_MK0, 8'h00);
    #1 check("R8 other group unmask", irq, 1'b0);
    wr(A_MK1, 8'h00);
    #1 check("R8 irq pending", irq, 1'b1);
    wr(A_ST1, 8'h04);
    #1 check("R8 irq cleared", irq, 1'b0);
    @(negedge clk);
    pin[9] = 1'b0;

    // R9: unused bits and unmapped addresses
    wr(A_MK0, 8'hFF);
    rd_chk("R9 mask0 top bit", A_MK0, 8'h7F);
    wr(A_MK1, 8'hFF);
    rd_chk("R9 mask1 top bits", A_MK1, 8'h3F);
    wr(16'h4E0D, 8'hFF);
    wr(16'h4E18, 8'h00);
    rd_chk("R9 unmapped read", 16'h4E0D, 8'h00);
    rd_chk("R9 unmapped write mask0", A_MK0, 8'h7F);
    rd_chk("R9 unmapped write mask1", A_MK1, 8'h3F);

    // R10: single-cycle pulse is caught
    wr(A_ST0, 8'hFF);
    @(negedge clk);
    pin[4] = 1'b1;
    @(negedge clk);
    pin[4] = 1'b0;
    rd_chk("R10 one-cycle pulse", A_ST0, 8'h10);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule